// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and memory and takes in processor stores, so the processor can continue without waiting for memory. Each entry covers one aligned block of several words. A new store is compared against every buffered block. If it hits an entry that is still open, its bytes are written over that entry's data and added to its byte mask, and no new slot is used. Memory therefore receives one wide block write per entry, with a per-byte mask, instead of a string of narrow word writes.

The processor also presents read lookups. A read to a block that is not buffered is told it may go to memory at once, ahead of older buffered writes. A read that touches a buffered block is either answered from the buffer, when every requested byte is present, or told to wait until the overlapping entries have reached memory. Entries leave oldest first over a valid/ready handshake. An entry that is being presented to memory is closed to merges, so a later store to that block takes a fresh slot.

Top module: `store_merge_buffer`

## Requirements
- R1: `st_ready` is high whenever a slot is free or the store's block hits an open entry. It is low only when all DEPTH slots are in use and no open entry hits.
- R2: An accepted store whose block (address bits above the block offset, 4 bits with the defaults) hits an open entry uses no new slot. Its enabled bytes overwrite that entry's bytes, and the entry's mask becomes the OR of the old mask and the new lanes.
- R3: An accepted store that hits no open entry fills the next free slot. The slot's mask holds only that store's lanes. Byte j of word w (address bits 3:2) maps to mask bit 4*w+j and to data bits 32*w+8*j upward.
- R4: Entries go to memory in allocation order, one transfer per entry. `mem_blk` is the block address, `mem_mask` is the merged byte mask (never zero) and `mem_data` holds all merged words.
- R5: Once `mem_valid` is high it stays high, with `mem_blk`, `mem_mask` and `mem_data` unchanged, until a cycle in which `mem_ready` is high.
- R6: Draining of the oldest entry begins, with `mem_valid` rising one cycle later, when occupancy reaches DRAIN_AT, when a read is told to wait, or when the buffer has held data for IDLE_LIMIT cycles with no accepted store.
- R7: The entry being presented to memory accepts no merges. A store to its block takes a new slot, or stalls if none is free.
- R8: A read whose block matches no buffered entry gets `rd_go` in the same cycle, whatever older writes are still buffered.
- R9: A read whose block is buffered and whose requested bytes are all present gets `rd_fwd`. `rd_data` then holds the newest buffered value of those bytes, with later entries taking precedence over older ones.
- R10: A read whose block is buffered but which lacks any requested byte gets `rd_wait`. Once the matching entries have drained, the same read gets `rd_go`.
- R11: A store accepted in the same cycle as a completed memory transfer takes effect in full. No entry is lost and none is sent twice.
- R12: After reset the buffer is empty, `st_ready` is high and `mem_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle if st_valid |
| st_addr | input | AW | Store byte address |
| st_data | input | WW | Store word |
| st_be | input | WW/8 | Store byte enables |
| rd_valid | input | 1 | Read lookup request |
| rd_addr | input | AW | Read byte address |
| rd_be | input | WW/8 | Requested bytes of the read word |
| rd_fwd | output | 1 | Read answered from buffer |
| rd_wait | output | 1 | Read must wait for draining |
| rd_go | output | 1 | Read may go to memory now |
| rd_data | output | WW | Forwarded word |
| mem_valid | output | 1 | Block write offered |
| mem_ready | input | 1 | Memory takes the block write |
| mem_blk | output | AW-log2(block bytes) | Block address of the write |
| mem_data | output | WW*WPB | Block data |
| mem_mask | output | WW*WPB/8 | Per-byte write mask |

## Verification
Stores are sent as repeated hits on one block, as a run of distinct blocks, as a hit on the block being drained, and as enough distinct blocks to fill every slot. Together these separate merging from allocation, oldest-first order from any other order, and a closed entry from an open one. Reads are tried against a block that is not buffered, a fully covered word, a partly covered word, and a word spread over a draining entry and a newer one, which separates bypass, forwarding with the right precedence, and waiting. A store and a completed transfer are placed in the same cycle, and the log of memory writes is checked for both loss and duplication.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [1:0] {
    RV_IDLE = 2'd0,
    RV_GO   = 2'd1,
    RV_FWD  = 2'd2,
    RV_WAIT = 2'd3
  } rd_kind_e;

  // step a ring index, wrapping at depth
  function automatic int ring_step(input int idx, input int depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/smb_slots.sv
module smb_slots #(
  parameter int AW    = 32,
  parameter int WW    = 32,
  parameter int WPB   = 4,
  parameter int DEPTH = 4,
  localparam int BPW  = WW / 8,
  localparam int BPB  = BPW * WPB,
  localparam int OFS  = $clog2(BPB),
  localparam int BAW  = AW - OFS,
  localparam int WIX  = $clog2(WPB),
  localparam int IW   = $clog2(DEPTH),
  localparam int LW   = BPB * 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [BAW-1:0]            wr_blk,
  input  logic [WIX-1:0]            wr_word,
  input  logic [WW-1:0]             wr_data,
  input  logic [BPW-1:0]            wr_be,
  input  logic                      closed_en,
  input  logic [IW-1:0]             closed_idx,
  input  logic [IW-1:0]             alloc_idx,
  input  logic                      clr_en,
  input  logic [IW-1:0]             clr_idx,
  output logic [DEPTH-1:0]          ent_vld,
  output logic [DEPTH-1:0][BAW-1:0] ent_blk,
  output logic [DEPTH-1:0][LW-1:0]  ent_data,
  output logic [DEPTH-1:0][BPB-1:0] ent_mask,
  output logic                      open_hit
);

  logic [DEPTH-1:0] hit_vec;
  logic [IW-1:0]    open_idx;
  logic [BPB-1:0]   new_lanes;
  logic [LW-1:0]    new_wide;

  // lanes of the block touched by one word store
  function automatic logic [BPB-1:0] lanes_of(input logic [WIX-1:0] w,
                                              input logic [BPW-1:0] be);
    return BPB'(be) << (int'(w) * BPW);
  endfunction

  // copy bytes of src into dst where sel is set
  function automatic logic [LW-1:0] overlay(input logic [LW-1:0] dst,
                                            input logic [LW-1:0] src,
                                            input logic [BPB-1:0] sel);
    logic [LW-1:0] r;
    r = dst;
    for (int b = 0; b < BPB; b++)
      if (sel[b]) r[b*8 +: 8] = src[b*8 +: 8];
    return r;
  endfunction

  assign new_lanes = lanes_of(wr_word, wr_be);
  assign new_wide  = {WPB{wr_data}};

  always_comb begin
    open_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_vec[i] = ent_vld[i] && (ent_blk[i] == wr_blk) &&
                   !(closed_en && (closed_idx == IW'(i)));
      if (hit_vec[i]) open_idx = IW'(i);
    end
  end

  assign open_hit = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld  <= '0;
      ent_blk  <= '0;
      ent_data <= '0;
      ent_mask <= '0;
    end else begin
      if (clr_en) ent_vld[clr_idx] <= 1'b0;
      if (wr_en) begin
        if (open_hit) begin
          ent_data[open_idx] <= overlay(ent_data[open_idx], new_wide, new_lanes);
          ent_mask[open_idx] <= ent_mask[open_idx] | new_lanes;
        end else begin
          ent_vld[alloc_idx]  <= 1'b1;
          ent_blk[alloc_idx]  <= wr_blk;
          ent_data[alloc_idx] <= overlay('0, new_wide, new_lanes);
          ent_mask[alloc_idx] <= new_lanes;
        end
      end
    end
  end

endmodule

// File: rtl/smb_drain.sv
module smb_drain #(
  parameter int DEPTH      = 4,
  parameter int DRAIN_AT   = 2,
  parameter int IDLE_LIMIT = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(IDLE_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          st_fire,
  input  logic          rd_block,
  input  logic          mem_ready,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic [CW-1:0] occ,
  output logic          busy,
  output logic          drain_fire,
  output logic          drain_start
);

  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] occ_q;
  logic [TW-1:0] idle_q;
  logic          busy_q;
  logic          trig;

  assign trig        = (occ_q >= CW'(DRAIN_AT)) || rd_block ||
                       (idle_q >= TW'(IDLE_LIMIT));
  assign drain_start = !busy_q && (occ_q != '0) && trig;
  assign drain_fire  = busy_q && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
      idle_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (drain_fire) head_q <= IW'(smb_pkg::ring_step(int'(head_q), DEPTH));
      if (alloc)      tail_q <= IW'(smb_pkg::ring_step(int'(tail_q), DEPTH));
      occ_q <= occ_q + CW'(alloc) - CW'(drain_fire);
      if (drain_fire)       busy_q <= 1'b0;
      else if (drain_start) busy_q <= 1'b1;
      if (st_fire || busy_q || occ_q == '0) idle_q <= '0;
      else if (idle_q < TW'(IDLE_LIMIT))    idle_q <= idle_q + 1'b1;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign occ  = occ_q;
  assign busy = busy_q;

endmodule

// File: rtl/smb_rdview.sv
module smb_rdview #(
  parameter int AW    = 32,
  parameter int WW    = 32,
  parameter int WPB   = 4,
  parameter int DEPTH = 4,
  localparam int BPW  = WW / 8,
  localparam int BPB  = BPW * WPB,
  localparam int OFS  = $clog2(BPB),
  localparam int BAW  = AW - OFS,
  localparam int WIX  = $clog2(WPB),
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int LW   = BPB * 8
) (
  input  logic                      rd_valid,
  input  logic [BAW-1:0]            rd_blk,
  input  logic [WIX-1:0]            rd_word,
  input  logic [BPW-1:0]            rd_be,
  input  logic [DEPTH-1:0]          ent_vld,
  input  logic [DEPTH-1:0][BAW-1:0] ent_blk,
  input  logic [DEPTH-1:0][LW-1:0]  ent_data,
  input  logic [DEPTH-1:0][BPB-1:0] ent_mask,
  input  logic [IW-1:0]             head,
  input  logic [CW-1:0]             occ,
  output smb_pkg::rd_kind_e         kind,
  output logic [WW-1:0]             data
);

  logic [LW-1:0]  acc;
  logic [BPB-1:0] cov;
  logic [BPW-1:0] cov_w;
  logic           any;

  // walk oldest to newest so that later entries overwrite earlier bytes
  always_comb begin
    acc = '0;
    cov = '0;
    any = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = (int'(head) + k) % DEPTH;
      if (k < int'(occ) && ent_vld[idx] && ent_blk[idx] == rd_blk) begin
        any = 1'b1;
        for (int b = 0; b < BPB; b++) begin
          if (ent_mask[idx][b]) begin
            acc[b*8 +: 8] = ent_data[idx][b*8 +: 8];
            cov[b] = 1'b1;
          end
        end
      end
    end
  end

  assign cov_w = cov[int'(rd_word)*BPW +: BPW];
  assign data  = acc[int'(rd_word)*WW +: WW];

  always_comb begin
    if (!rd_valid)                    kind = smb_pkg::RV_IDLE;
    else if (!any)                    kind = smb_pkg::RV_GO;
    else if ((rd_be & ~cov_w) == '0)  kind = smb_pkg::RV_FWD;
    else                              kind = smb_pkg::RV_WAIT;
  end

endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer #(
  parameter int AW         = 32,
  parameter int WW         = 32,
  parameter int WPB        = 4,
  parameter int DEPTH      = 4,
  parameter int DRAIN_AT   = 2,
  parameter int IDLE_LIMIT = 8,
  localparam int BPW = WW / 8,
  localparam int BPB = BPW * WPB,
  localparam int OFS = $clog2(BPB),
  localparam int WSB = $clog2(BPW),
  localparam int BAW = AW - OFS,
  localparam int WIX = $clog2(WPB),
  localparam int IW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int LW  = BPB * 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           st_valid,
  output logic           st_ready,
  input  logic [AW-1:0]  st_addr,
  input  logic [WW-1:0]  st_data,
  input  logic [BPW-1:0] st_be,
  input  logic           rd_valid,
  input  logic [AW-1:0]  rd_addr,
  input  logic [BPW-1:0] rd_be,
  output logic           rd_fwd,
  output logic           rd_wait,
  output logic           rd_go,
  output logic [WW-1:0]  rd_data,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [BAW-1:0] mem_blk,
  output logic [LW-1:0]  mem_data,
  output logic [BPB-1:0] mem_mask
);

  // named internal events
  logic st_fire, st_merge, st_alloc, drain_fire, drain_start, busy, open_hit;
  logic [IW-1:0] head, tail;
  logic [CW-1:0] occ;

  logic [DEPTH-1:0]          ent_vld;
  logic [DEPTH-1:0][BAW-1:0] ent_blk;
  logic [DEPTH-1:0][LW-1:0]  ent_data;
  logic [DEPTH-1:0][BPB-1:0] ent_mask;
  smb_pkg::rd_kind_e         rkind;

  function automatic logic [BAW-1:0] blk_of(input logic [AW-1:0] a);
    return a[AW-1:OFS];
  endfunction

  function automatic logic [WIX-1:0] word_of(input logic [AW-1:0] a);
    return a[OFS-1:WSB];
  endfunction

  assign st_ready = (occ != CW'(DEPTH)) || open_hit;
  assign st_fire  = st_valid && st_ready;
  assign st_merge = st_fire && open_hit;
  assign st_alloc = st_fire && !open_hit;

  smb_slots #(.AW(AW), .WW(WW), .WPB(WPB), .DEPTH(DEPTH)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (st_fire),
    .wr_blk     (blk_of(st_addr)),
    .wr_word    (word_of(st_addr)),
    .wr_data    (st_data),
    .wr_be      (st_be),
    .closed_en  (busy),
    .closed_idx (head),
    .alloc_idx  (tail),
    .clr_en     (drain_fire),
    .clr_idx    (head),
    .ent_vld    (ent_vld),
    .ent_blk    (ent_blk),
    .ent_data   (ent_data),
    .ent_mask   (ent_mask),
    .open_hit   (open_hit)
  );

  smb_drain #(.DEPTH(DEPTH), .DRAIN_AT(DRAIN_AT), .IDLE_LIMIT(IDLE_LIMIT)) u_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc       (st_alloc),
    .st_fire     (st_fire),
    .rd_block    (rd_wait),
    .mem_ready   (mem_ready),
    .head        (head),
    .tail        (tail),
    .occ         (occ),
    .busy        (busy),
    .drain_fire  (drain_fire),
    .drain_start (drain_start)
  );

  smb_rdview #(.AW(AW), .WW(WW), .WPB(WPB), .DEPTH(DEPTH)) u_rdview (
    .rd_valid (rd_valid),
    .rd_blk   (blk_of(rd_addr)),
    .rd_word  (word_of(rd_addr)),
    .rd_be    (rd_be),
    .ent_vld  (ent_vld),
    .ent_blk  (ent_blk),
    .ent_data (ent_data),
    .ent_mask (ent_mask),
    .head     (head),
    .occ      (occ),
    .kind     (rkind),
    .data     (rd_data)
  );

  assign rd_fwd  = (rkind == smb_pkg::RV_FWD);
  assign rd_wait = (rkind == smb_pkg::RV_WAIT);
  assign rd_go   = (rkind == smb_pkg::RV_GO);

  assign mem_valid = busy;
  assign mem_blk   = ent_blk[head];
  assign mem_data  = ent_data[head];
  assign mem_mask  = ent_mask[head];

endmodule

// File: rtl/smb_checker.sv
module smb_checker #(
  parameter int DEPTH = 4,
  parameter int BAW   = 28,
  parameter int LW    = 128,
  parameter int BPB   = 16,
  parameter int CW    = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           st_valid,
  input logic           st_ready,
  input logic           st_merge,
  input logic           st_alloc,
  input logic           drain_fire,
  input logic [CW-1:0]  occ,
  input logic           rd_valid,
  input logic           rd_fwd,
  input logic           rd_wait,
  input logic           rd_go,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic [BAW-1:0] mem_blk,
  input logic [LW-1:0]  mem_data,
  input logic [BPB-1:0] mem_mask
);

  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |-> occ == CW'(DEPTH)); // R1

  AST_MERGE_KEEPS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    st_merge && !drain_fire |=> occ == $past(occ)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R3

  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_mask != '0); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid); // R5

  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> $stable(mem_blk) && $stable(mem_mask) && $stable(mem_data)); // R5

  AST_RD_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $countones({rd_fwd, rd_wait, rd_go}) == 1); // R8

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !(rd_fwd || rd_wait || rd_go)); // R10

  AST_BOTH_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    st_alloc && drain_fire |=> occ == $past(occ)); // R11

endmodule

bind store_merge_buffer smb_checker #(
  .DEPTH(DEPTH), .BAW(BAW), .LW(LW), .BPB(BPB), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_valid   (st_valid),
  .st_ready   (st_ready),
  .st_merge   (st_merge),
  .st_alloc   (st_alloc),
  .drain_fire (drain_fire),
  .occ        (occ),
  .rd_valid   (rd_valid),
  .rd_fwd     (rd_fwd),
  .rd_wait    (rd_wait),
  .rd_go      (rd_go),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_blk    (mem_blk),
  .mem_data   (mem_data),
  .mem_mask   (mem_mask)
);

// File: tb/store_merge_buffer_test.sv
module store_merge_buffer_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic         st_valid;
  logic         st_ready;
  logic [31:0]  st_addr;
  logic [31:0]  st_data;
  logic [3:0]   st_be;
  logic         rd_valid;
  logic [31:0]  rd_addr;
  logic [3:0]   rd_be;
  logic         rd_fwd, rd_wait, rd_go;
  logic [31:0]  rd_data;
  logic         mem_valid;
  logic         mem_ready;
  logic [27:0]  mem_blk;
  logic [127:0] mem_data;
  logic [15:0]  mem_mask;

  int n_chk  = 0;
  int n_fail = 0;

  logic [27:0]  lg_blk  [32];
  logic [127:0] lg_data [32];
  logic [15:0]  lg_mask [32];
  int           lg_n = 0;

  store_merge_buffer uut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_be(rd_be),
    .rd_fwd(rd_fwd), .rd_wait(rd_wait), .rd_go(rd_go), .rd_data(rd_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_blk(mem_blk),
    .mem_data(mem_data), .mem_mask(mem_mask)
  );

  // memory responder: log each accepted block write
  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (lg_n < 32) begin
        lg_blk[lg_n]  <= mem_blk;
        lg_data[lg_n] <= mem_data;
        lg_mask[lg_n] <= mem_mask;
      end
      lg_n <= lg_n + 1;
    end
  end

  function automatic logic [127:0] bytes_of(input logic [15:0] m);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) if (m[i]) r[i*8 +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 st_valid = 1'b0;
  endtask

  task automatic probe(input logic [31:0] a, output logic rdy);
    @(negedge clk);
    st_valid = 1'b0; st_addr = a;
    #1 rdy = st_ready;
  endtask

  task automatic look(input logic [31:0] a, input logic [3:0] be,
                      output logic [2:0] res, output logic [31:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_be = be;
    #1 res = {rd_fwd, rd_wait, rd_go}; d = rd_data;
    @(posedge clk);
    #1 rd_valid = 1'b0;
  endtask

  task automatic wait_log(input int n, input string tag);
    int t = 0;
    while (lg_n < n && t < 100) begin @(negedge clk); t++; end
    chk(lg_n >= n, tag, 128'(lg_n), 128'(n));
  endtask

  task automatic chk_log(input int i, input logic [27:0] b, input logic [15:0] m,
                         input logic [127:0] d, input string tag);
    chk(lg_blk[i] == b, {tag, " blk"}, 128'(lg_blk[i]), 128'(b));
    chk(lg_mask[i] == m, {tag, " mask"}, 128'(lg_mask[i]), 128'(m));
    chk((lg_data[i] & bytes_of(m)) == (d & bytes_of(m)), {tag, " data"},
        lg_data[i] & bytes_of(m), d & bytes_of(m));
  endtask

  // R12, R8: empty after reset, read of any block may bypass
  task automatic t_reset();
    logic [2:0] r; logic [31:0] d;
    chk(st_ready == 1'b1, "R12 st_ready", 128'(st_ready), 128'(1));
    chk(mem_valid == 1'b0, "R12 mem_valid", 128'(mem_valid), 128'(0));
    look(32'h0, 4'hF, r, d);
    chk(r == 3'b001, "R8 empty read go", 128'(r), 128'(3'b001));
  endtask

  // R2, R9, R10, R8, R4: merging into one block, forward, wait, then bypass
  task automatic t_merge();
    logic [2:0] r; logic [31:0] d; int base;
    mem_ready = 1'b0; base = lg_n;
    put(32'h1000, 32'h11111111, 4'hF);
    put(32'h1008, 32'h0000AABB, 4'b0011);
    put(32'h1000, 32'h00000022, 4'b0001);
    look(32'h1000, 4'hF, r, d);
    chk(r == 3'b100, "R9 covered word fwd", 128'(r), 128'(3'b100));
    chk(d == 32'h11111122, "R2 merged overwrite", 128'(d), 128'(32'h11111122));
    look(32'h1008, 4'b0011, r, d);
    chk(r == 3'b100 && d[15:0] == 16'hAABB, "R9 partial word fwd", 128'({r, d[15:0]}),
        128'({3'b100, 16'hAABB}));
    look(32'h1008, 4'b0100, r, d);
    chk(r == 3'b010, "R10 missing byte wait", 128'(r), 128'(3'b010));
    @(negedge clk);
    chk(mem_valid && mem_blk == 28'h100, "R10 wait starts drain", 128'({mem_valid, mem_blk}),
        128'({1'b1, 28'h100}));
    mem_ready = 1'b1;
    wait_log(base + 1, "R4 merged drain");
    mem_ready = 1'b0;
    chk_log(base, 28'h100, 16'h030F, {32'h0, 32'h0000AABB, 32'h0, 32'h11111122}, "R2 R4 one write");
    chk(lg_n == base + 1, "R2 single transfer", 128'(lg_n), 128'(base + 1));
    look(32'h1008, 4'b0100, r, d);
    chk(r == 3'b001, "R10 go after drain", 128'(r), 128'(3'b001));
  endtask

  // R3, R4, R5, R6, R7, R9: order, handshake hold, closed entry
  task automatic t_order();
    logic [2:0] r; logic [31:0] d; int base;
    mem_ready = 1'b0; base = lg_n;
    put(32'h2000, 32'hB0B0B0B0, 4'hF);
    put(32'h300C, 32'hC3C3C3C3, 4'hF);
    repeat (2) @(negedge clk);
    chk(mem_valid == 1'b1, "R6 occupancy trigger", 128'(mem_valid), 128'(1));
    chk(mem_blk == 28'h200, "R4 oldest first", 128'(mem_blk), 128'(28'h200));
    repeat (3) @(negedge clk);
    chk(mem_valid && mem_blk == 28'h200 && mem_mask == 16'h000F, "R5 held without ready",
        128'({mem_valid, mem_blk, mem_mask}), 128'({1'b1, 28'h200, 16'h000F}));
    put(32'h2000, 32'h000000CC, 4'b0001);
    look(32'h2000, 4'hF, r, d);
    chk(r == 3'b100 && d == 32'hB0B0B0CC, "R9 newer entry wins", 128'({r, d}),
        128'({3'b100, 32'hB0B0B0CC}));
    mem_ready = 1'b1;
    wait_log(base + 3, "R4 three writes");
    mem_ready = 1'b0;
    chk_log(base,     28'h200, 16'h000F, 128'h0000_0000_0000_0000_0000_0000_B0B0B0B0, "R4 first");
    chk_log(base + 1, 28'h300, 16'hF000, {32'hC3C3C3C3, 96'h0}, "R3 lanes word3");
    chk_log(base + 2, 28'h200, 16'h0001, 128'h0000_0000_0000_0000_0000_0000_000000CC, "R7 new slot");
  endtask

  // R6: a lone entry leaves after the idle window
  task automatic t_idle();
    int base;
    mem_ready = 1'b1; base = lg_n;
    put(32'h4004, 32'h44444444, 4'hF);
    repeat (5) @(negedge clk);
    chk(mem_valid == 1'b0 && lg_n == base, "R6 no early drain", 128'({mem_valid, 8'(lg_n - base)}),
        128'({1'b0, 8'h0}));
    wait_log(base + 1, "R6 idle drain");
    mem_ready = 1'b0;
    chk_log(base, 28'h400, 16'h00F0, {64'h0, 32'h44444444, 32'h0}, "R6 idle entry");
  endtask

  // R1, R7, R11: full buffer, closed head, store with completed transfer
  task automatic t_full();
    logic rdy; int base;
    mem_ready = 1'b0; base = lg_n;
    put(32'h5000, 32'h50505050, 4'hF);
    put(32'h6000, 32'h60606060, 4'hF);
    put(32'h7000, 32'h70707070, 4'hF);
    repeat (2) @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h8000; st_data = 32'h80808080; st_be = 4'hF;
    mem_ready = 1'b1;
    #1;
    chk(st_ready && mem_valid, "R11 both offered", 128'({st_ready, mem_valid}), 128'(2'b11));
    @(posedge clk);
    #1 st_valid = 1'b0; mem_ready = 1'b0;
    put(32'h9000, 32'h90909090, 4'hF);
    @(negedge clk);
    probe(32'hA000, rdy);
    chk(rdy == 1'b0, "R1 full stall", 128'(rdy), 128'(0));
    probe(32'h6000, rdy);
    chk(rdy == 1'b0, "R7 closed head no merge", 128'(rdy), 128'(0));
    probe(32'h7004, rdy);
    chk(rdy == 1'b1, "R1 open merge while full", 128'(rdy), 128'(1));
    put(32'h7004, 32'h71717171, 4'hF);
    mem_ready = 1'b1;
    wait_log(base + 5, "R11 all drained");
    mem_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk(lg_n == base + 5, "R11 no duplicate", 128'(lg_n), 128'(base + 5));
    chk_log(base,     28'h500, 16'h000F, {96'h0, 32'h50505050}, "R11 drained entry");
    chk_log(base + 1, 28'h600, 16'h000F, {96'h0, 32'h60606060}, "R4 second");
    chk_log(base + 2, 28'h700, 16'h00FF, {64'h0, 32'h71717171, 32'h70707070}, "R2 merged when full");
    chk_log(base + 3, 28'h800, 16'h000F, {96'h0, 32'h80808080}, "R11 same-cycle store");
    chk_log(base + 4, 28'h900, 16'h000F, {96'h0, 32'h90909090}, "R3 last");
  endtask

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
    rd_valid = 1'b0; rd_addr = '0; rd_be = '0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_merge();
    t_order();
    t_idle();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule